// File: doc/BRIEF.md
# I2C Block-Transfer Configuration Slave

This block is an I2C slave that holds a small bank of 8-bit configuration registers for a clock generator. The host writes in block form: after the address it sends a command byte and a byte-count byte, both acknowledged and then dropped. The data bytes that follow fill the bank strictly in order, starting at byte 0. A STOP may follow any complete byte, and every byte already received stays stored.

A read returns a byte count first and then the whole bank, byte 0 first. SCL and SDA are oversampled by a fast system clock through a two-flop synchronizer, and all bus events are detected in that clock domain. SDA is driven open-drain: the block only asserts an enable that pulls the line low. The register contents are presented in parallel on a single output vector.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave responds only to 7-bit address 0x69, that is the byte 0xD2 for a write and 0xD3 for a read. Any other address is not acknowledged and changes no register.
- R2: In a write, the two bytes after the address (command, then count) are acknowledged, and their values have no effect on the bank.
- R3: Write data bytes go to register 0, 1, 2 and so on in arrival order. On a STOP after k complete data bytes, registers 0..k-1 hold the new values and the rest are unchanged.
- R4: A START or STOP that arrives before the eighth bit of a data byte discards that byte. No register changes.
- R5: Data bytes beyond the sixth are acknowledged and discarded.
- R6: After reset the bank holds byte0=0x1E, byte1=0xFF, byte2=0xFF, byte3=0x00, byte4=0x00, byte5=0x06. Byte k sits at bits [8k+7:8k] of `cfg_bank_o`.
- R7: Bits 7:4 of byte 0 are read-only: a write changes only bits 3:0 of that byte.
- R8: A read returns the count 6 and then bytes 0 to 5, each sent MSB first. The host acknowledges each byte, and a NACK from the host ends the transfer.
- R9: The slave acknowledges the address and every write byte by pulling SDA low during the ninth clock. It changes its SDA drive only while SCL is low.
- R10: After a STOP the slave releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| cfg_bank_o | output | 8*NUM_REGS | Register bank, byte k at bits [8k+7:8k] |

## Verification
Two events can land on the same system-clock cycle: storing a byte at its eighth SCL rise, and a bus START or STOP that cuts a transfer short. The bench ends writes right after the last whole byte, and it also ends them a few bits into the next byte, using both STOP and START. It then compares the bank against a model in which only whole bytes count. Random block writes of 0 to 8 data bytes, with read-backs between them, also make the end of a write fall on every register and beyond the bank.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_RX,
    LNK_RX_END,
    LNK_ACK,
    LNK_TX,
    LNK_TX_END,
    LNK_MACK,
    LNK_MACK_END
  } link_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int                    NUM_REGS  = 6,
  parameter int                    IDX_W     = 4,
  parameter logic [8*NUM_REGS-1:0] RESET_VAL = '0,
  parameter logic [8*NUM_REGS-1:0] RO_MASK   = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [8*NUM_REGS-1:0] bank_o
);

  logic [8*NUM_REGS-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= RESET_VAL;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (int'(wr_idx) == i) begin
          bank_q[i*8 +: 8] <= (wr_data & ~RO_MASK[i*8 +: 8]) |
                              (bank_q[i*8 +: 8] & RO_MASK[i*8 +: 8]);
        end
      end
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(rd_idx) == i) rd_data = bank_q[i*8 +: 8];
    end
  end

  assign bank_o = bank_q;

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0]            DEV_ADDR    = 7'h69,
  parameter int                    NUM_REGS    = 6,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [8*NUM_REGS-1:0] RESET_VAL   = 48'h06_00_00_FF_FF_1E,
  parameter logic [8*NUM_REGS-1:0] RO_MASK     = 48'h00_00_00_00_00_F0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [8*NUM_REGS-1:0] cfg_bank_o
);

  localparam int HDR_BYTES = 2;
  localparam int PH_W      = $clog2(NUM_REGS + HDR_BYTES + 1);
  localparam logic [PH_W-1:0] PH_MAX = '1;

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  link_state_t     state;
  logic [2:0]      bit_cnt;
  logic [7:0]      shreg;
  logic [PH_W-1:0] phase;
  logic            in_addr, is_read, ack_go, oe_q;

  logic [7:0]      rx_byte, tx_byte, rd_data;
  logic            wr_en;
  logic [PH_W-1:0] wr_idx, rd_idx;
  logic            byte_done;

  assign rx_byte   = {shreg[6:0], sda_s};
  assign byte_done = (state == LNK_RX) && scl_rise && (bit_cnt == 3'd7);
  assign wr_en     = byte_done && !in_addr && !is_read &&
                     (int'(phase) >= HDR_BYTES) &&
                     (int'(phase) < NUM_REGS + HDR_BYTES);
  assign wr_idx    = phase - PH_W'(HDR_BYTES);
  assign rd_idx    = phase - PH_W'(1);
  assign tx_byte   = (phase == '0) ? 8'(NUM_REGS) : rd_data;

  cfg_reg_bank #(
    .NUM_REGS  (NUM_REGS),
    .IDX_W     (PH_W),
    .RESET_VAL (RESET_VAL),
    .RO_MASK   (RO_MASK)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (rx_byte),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .bank_o  (cfg_bank_o)
  );

  function automatic logic [PH_W-1:0] ph_next(input logic [PH_W-1:0] p);
    return (p == PH_MAX) ? p : p + PH_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LNK_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      phase   <= '0;
      in_addr <= 1'b0;
      is_read <= 1'b0;
      ack_go  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_evt) begin
      state   <= LNK_RX;
      bit_cnt <= '0;
      phase   <= '0;
      in_addr <= 1'b1;
      is_read <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_evt) begin
      state   <= LNK_IDLE;
      oe_q    <= 1'b0;
    end else begin
      case (state)
        LNK_RX: if (scl_rise) begin
          shreg   <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            state <= LNK_RX_END;
            if (in_addr) begin
              is_read <= sda_s;
              ack_go  <= (rx_byte[7:1] == DEV_ADDR);
            end else begin
              ack_go  <= 1'b1;
              phase   <= ph_next(phase);
            end
          end
        end
        LNK_RX_END: if (scl_fall) begin
          if (ack_go) begin
            oe_q  <= 1'b1;
            state <= LNK_ACK;
          end else begin
            state <= LNK_IDLE;
          end
        end
        LNK_ACK: if (scl_fall) begin
          in_addr <= 1'b0;
          bit_cnt <= '0;
          if (is_read) begin
            shreg <= tx_byte;
            oe_q  <= ~tx_byte[7];
            state <= LNK_TX;
          end else begin
            oe_q  <= 1'b0;
            state <= LNK_RX;
          end
        end
        LNK_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) state <= LNK_TX_END;
          end else if (scl_fall) begin
            shreg <= {shreg[6:0], 1'b1};
            oe_q  <= ~shreg[6];
          end
        end
        LNK_TX_END: if (scl_fall) begin
          oe_q  <= 1'b0;
          phase <= ph_next(phase);
          state <= LNK_MACK;
        end
        LNK_MACK: if (scl_rise) begin
          state <= sda_s ? LNK_IDLE : LNK_MACK_END;
        end
        LNK_MACK_END: if (scl_fall) begin
          shreg   <= tx_byte;
          oe_q    <= ~tx_byte[7];
          bit_cnt <= '0;
          state   <= LNK_TX;
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int                    NUM_REGS  = 6,
  parameter logic [8*NUM_REGS-1:0] RESET_VAL = '0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic [8*NUM_REGS-1:0] cfg_bank_o,
  input logic                  stop_evt
);

  // R6
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_bank_o == RESET_VAL));

  // R7
  id_bits_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(cfg_bank_o[7:4]));

  // R3
  store_on_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_bank_o != $past(cfg_bank_o)) |-> scl_i);

  // R9
  drive_hold_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i, 1) && $past(scl_i, 2) && $past(scl_i, 3) && $past(scl_i, 4))
      |-> $stable(sda_oe_o));

  // R10
  release_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe_o);

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(
  .NUM_REGS  (NUM_REGS),
  .RESET_VAL (RESET_VAL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .cfg_bank_o (cfg_bank_o),
  .stop_evt   (stop_evt)
);

// File: tb/test_cfg_i2c_slave.sv
`timescale 1ns/1ps
module test_cfg_i2c_slave;

  localparam int NREG = 6;
  localparam int Q    = 10;
  localparam logic [8*NREG-1:0] DEF = 48'h06_00_00_FF_FF_1E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [8*NREG-1:0] bank;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  cfg_i2c_slave i_cfg_i2c_slave (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .cfg_bank_o (bank)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [8*NREG-1:0] model;
  logic [7:0] wbuf [0:15];
  logic done = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8*NREG-1:0] apply_write(input logic [8*NREG-1:0] old, input int n);
    logic [8*NREG-1:0] r = old;
    for (int i = 0; i < n && i < NREG; i++) begin
      if (i == 0) r[7:0] = {old[7:4], wbuf[0][3:0]};
      else        r[i*8 +: 8] = wbuf[i];
    end
    return r;
  endfunction

  task automatic wait_q();
    repeat (Q) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_q(); scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    b = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    put_bit(~host_ack);
  endtask

  // block write: address, command, count, then n bytes from wbuf
  task automatic block_write(input logic [7:0] adr, input int n, output logic all_ack);
    logic a;
    bus_start();
    send_byte(adr, a);
    all_ack = a;
    if (a) begin
      send_byte(8'($urandom()), a); all_ack &= a;
      send_byte(8'($urandom()), a); all_ack &= a;
      for (int i = 0; i < n; i++) begin
        send_byte(wbuf[i], a);
        all_ack &= a;
      end
    end
    bus_stop();
  endtask

  task automatic block_read(output logic addr_ack, output logic [7:0] cnt,
                            output logic [8*NREG-1:0] got);
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, addr_ack);
    recv_byte(1'b1, cnt);
    for (int i = 0; i < NREG; i++) begin
      recv_byte(i != NREG - 1, b);
      got[i*8 +: 8] = b;
    end
    bus_stop();
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    logic ok, aa;
    logic [7:0] cnt;
    logic [8*NREG-1:0] got;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (10) @(posedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R6 reset state
    check("R6 reset bank", 64'(bank), 64'(DEF));
    check("R10 idle release", 64'(sda_oe), 64'd0);
    model = DEF;

    // R2 R3 R7 full write, command/count ignored
    wbuf[0] = 8'hAB; wbuf[1] = 8'h12; wbuf[2] = 8'h34;
    wbuf[3] = 8'h56; wbuf[4] = 8'h78; wbuf[5] = 8'h9A;
    block_write(8'hD2, 6, ok);
    @(negedge clk);
    check("R2 R9 acks full write", 64'(ok), 64'd1);
    model = apply_write(model, 6);
    check("R3 R7 full write bank", 64'(bank), 64'(model));
    check("R7 id nibble", 64'(bank[7:4]), 64'h1);
    check("R10 release after stop", 64'(sda_oe), 64'd0);

    // R8 read back
    block_read(aa, cnt, got);
    check("R1 read address ack", 64'(aa), 64'd1);
    check("R8 count byte", 64'(cnt), 64'd6);
    check("R8 read data", 64'(got), 64'(model));

    // R3 partial write of 2 bytes
    wbuf[0] = 8'h05; wbuf[1] = 8'hC3;
    block_write(8'hD2, 2, ok);
    @(negedge clk);
    model = apply_write(model, 2);
    check("R3 partial write", 64'(bank), 64'(model));

    // R5 overlong write
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h21 * (i + 1));
    block_write(8'hD2, 8, ok);
    @(negedge clk);
    check("R5 overlong acked", 64'(ok), 64'd1);
    model = apply_write(model, 8);
    check("R5 overlong bank", 64'(bank), 64'(model));

    // R1 foreign address
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    block_write(8'hA0, 2, ok);
    @(negedge clk);
    check("R1 foreign nack", 64'(ok), 64'd0);
    check("R1 foreign no change", 64'(bank), 64'(model));

    // R4 mid-byte STOP
    bus_start();
    send_byte(8'hD2, aa); send_byte(8'h00, aa); send_byte(8'h00, aa);
    send_byte(8'h0F, aa);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    @(negedge clk);
    wbuf[0] = 8'h0F;
    model = apply_write(model, 1);
    check("R4 stop aborts partial byte", 64'(bank), 64'(model));

    // R4 mid-byte START
    bus_start();
    send_byte(8'hD2, aa); send_byte(8'h00, aa); send_byte(8'h00, aa);
    send_byte(8'h02, aa);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_start();
    bus_stop();
    @(negedge clk);
    wbuf[0] = 8'h02;
    model = apply_write(model, 1);
    check("R4 start aborts partial byte", 64'(bank), 64'(model));

    // random block writes with periodic read-back
    for (int t = 0; t < 14; t++) begin
      int n;
      n = int'($urandom_range(0, 8));
      for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom());
      block_write(8'hD2, n, ok);
      @(negedge clk);
      model = apply_write(model, n);
      check("R3 random write acks", 64'(ok), 64'd1);
      check("R3 random write bank", 64'(bank), 64'(model));
      if (t % 4 == 3) begin
        block_read(aa, cnt, got);
        check("R8 random read", 64'(got), 64'(model));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule